// File: doc/BRIEF.md
# Stepper Phase and Print-Head Buffer Controller

This block is a small bus-mapped peripheral for a dot-matrix print mechanism. Software reaches it through an 8-bit data bus qualified by a chip select and separate read and write strobes. It keeps a mode register, two stepper-motor channels (paper feed and carriage), and a pair of buffers for the 9-wire print head.

Each motor channel drives a 4-bit phase pattern. Software either writes that pattern directly or lets the channel step on its own external step input. In stepping mode the channel walks the two-phases-on sequence forward or backward, depending on a direction bit. Head data is assembled in a first buffer. The rising edge of the head drive pulse copies it into a second buffer, which drives the head wires while the pulse stays high. An optional protection mode removes any dot that would fire in two columns in a row.

The bus is synchronous to `clk`. A strobe is acted on in every cycle that `cs` and the strobe are both high. Read data is registered and appears on `rdata` in the cycle after the read. Reset is synchronous and active high.

Top module: `prnmech_ctrl`

## Requirements
- R1: After reset the mode register, both phase outputs, both head buffers, `head_out`, `bank_sel` and `rdata` are all zero.
- R2: A write to address 0 stores data bits 6..0 in the mode register. A read of address 0 returns them, with bit 7 always 0. `bank_sel[1]` follows mode bit 6 and `bank_sel[0]` follows mode bit 5.
- R3: Address 3 is the paper feed phase register and address 4 is the carriage phase register. A write stores data bits 3..0. A read returns them with bits 7..4 zero. The phase output equals the register, using the bit order A=bit3, C=bit2, B=bit1, D=bit0.
- R4: A mode bit of 0 selects stepping mode (bit 1 for paper feed, bit 3 for carriage). With the direction bit at 0 (bit 2 for paper feed, bit 4 for carriage), each rising edge of the channel's step input moves the phase through 0xA, 0x6, 0x5, 0x9 and back to 0xA (A+B, B+C, C+D, D+A).
- R5: With the direction bit at 1, each rising step edge moves the phase backward: 0xA, 0x9, 0x5, 0x6, 0xA.
- R6: With the mode bit at 1 (software mode), step edges leave the phase unchanged. In stepping mode, a step input held high advances the phase only once.
- R7: In stepping mode, a step edge while the phase holds a pattern outside the four-step sequence loads 0xA.
- R8: If a phase register write and a step edge for the same channel fall in the same cycle, the written value is kept.
- R9: A write to address 2 loads head bits 7..0 of the first buffer. A write to address 1 loads head bit 8 from data bit 7. The rising edge of `drive_pulse` copies the first buffer into the second and leaves the first buffer unchanged.
- R10: `head_out` equals the second buffer, including a value loaded at that edge, in any cycle where `drive_pulse` was sampled high. It is zero in any cycle where `drive_pulse` was sampled low.
- R11: With mode bit 0 set, the copy into the second buffer clears every dot that was also set in the second buffer's previous contents. With mode bit 0 clear, the copy is unchanged.
- R12: A read of address 1 clears the first buffer and a read of address 2 clears the second buffer. Both reads return 0.
- R13: Addresses 5 to 7 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pf_step | input | 1 | Paper feed step input |
| cr_step | input | 1 | Carriage step input |
| drive_pulse | input | 1 | Head drive pulse |
| pf_phase | output | 4 | Paper feed phases (A,C,B,D) |
| cr_phase | output | 4 | Carriage phases (A,C,B,D) |
| head_out | output | 9 | Gated head wire data |
| bank_sel | output | 2 | Bank select bits from the mode register |

## Verification
The bench walks each channel through a full forward cycle and part of a reverse one. A design with the B and C bit positions swapped would show 0xC instead of 0x6. The bench also seeds a channel with an invalid two-hot pattern: a design without the reseed would keep stepping a wrong pattern or stay stuck at zero. It holds the step input high for several cycles to catch level-triggered stepping. It fires a step and a phase write in the same cycle; a design with the wrong priority ends one step ahead of the written value. On the head side, the bench sends overlapping columns with protection on and off, and clears each buffer separately. A design that gates on the previous output instead of the previous buffer, or that clears the wrong buffer, then shows a different dot pattern.

// File: rtl/prnmech_pkg.sv
package prnmech_pkg;
  localparam int DW     = 8;
  localparam int AW     = 3;
  localparam int PH_W   = 4;
  localparam int HEAD_W = DW + 1;
  localparam int N_CH   = 2;

  localparam logic [AW-1:0] A_MODE  = 3'd0;
  localparam logic [AW-1:0] A_HD_HI = 3'd1;
  localparam logic [AW-1:0] A_HD_LO = 3'd2;
  localparam logic [AW-1:0] A_PH0   = 3'd3;

  localparam int MB_PROT  = 0;
  localparam int MB_BANK0 = 5;
  localparam int MB_BANK1 = 6;
  localparam int MODE_W   = 7;

  // register order is A,C,B,D; sequence order is A,B,C,D
  function automatic logic [PH_W-1:0] swap_bc(input logic [PH_W-1:0] v);
    return {v[3], v[1], v[2], v[0]};
  endfunction
endpackage

// File: rtl/step_phase_chan.sv
module step_phase_chan
  import prnmech_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            auto_en,
  input  logic            reverse,
  input  logic            wr_en,
  input  logic [PH_W-1:0] wr_phase,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] SEED = {2'b11, {(PH_W-2){1'b0}}};

  logic            step_d;
  logic            step_rise;
  logic [PH_W-1:0] seq_now;
  logic [PH_W-1:0] seq_nxt;
  logic            in_seq;

  always_ff @(posedge clk) step_d <= step;
  assign step_rise = step & ~step_d;

  assign seq_now = swap_bc(phase);

  always_comb begin
    logic [PH_W-1:0] probe;
    in_seq = 1'b0;
    probe  = SEED;
    for (int k = 0; k < PH_W; k++) begin
      if (seq_now == probe) in_seq = 1'b1;
      probe = {probe[0], probe[PH_W-1:1]};
    end
    if (!in_seq)      seq_nxt = SEED;
    else if (reverse) seq_nxt = {seq_now[PH_W-2:0], seq_now[PH_W-1]};
    else              seq_nxt = {seq_now[0], seq_now[PH_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)                        phase <= '0;
    else if (wr_en)                 phase <= wr_phase;
    else if (auto_en && step_rise)  phase <= swap_bc(seq_nxt);
  end
endmodule

// File: rtl/head_dot_buf.sv
module head_dot_buf
  import prnmech_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DW-1:0]     wdata,
  input  logic              clr_first,
  input  logic              clr_second,
  input  logic              pulse,
  input  logic              prot_en,
  output logic [HEAD_W-1:0] head_out
);
  logic [HEAD_W-1:0] first_q;
  logic [HEAD_W-1:0] second_q;
  logic [HEAD_W-1:0] second_nxt;
  logic              pulse_d;
  logic              xfer;

  always_ff @(posedge clk) begin
    if (rst) pulse_d <= 1'b0;
    else     pulse_d <= pulse;
  end
  assign xfer = pulse & ~pulse_d;

  always_ff @(posedge clk) begin
    if (rst || clr_first) first_q <= '0;
    else begin
      if (ld_lo) first_q[DW-1:0]   <= wdata;
      if (ld_hi) first_q[HEAD_W-1] <= wdata[DW-1];
    end
  end

  always_comb begin
    if (clr_second)   second_nxt = '0;
    else if (xfer)    second_nxt = prot_en ? (first_q & ~second_q) : first_q;
    else              second_nxt = second_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q <= '0;
      head_out <= '0;
    end else begin
      second_q <= second_nxt;
      head_out <= pulse ? second_nxt : '0;
    end
  end
endmodule

// File: rtl/prnmech_ctrl.sv
module prnmech_ctrl
  import prnmech_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              pf_step,
  input  logic              cr_step,
  input  logic              drive_pulse,
  output logic [PH_W-1:0]   pf_phase,
  output logic [PH_W-1:0]   cr_phase,
  output logic [HEAD_W-1:0] head_out,
  output logic [1:0]        bank_sel
);
  logic              wr_hit;
  logic              rd_hit;
  logic [MODE_W-1:0] mode_q;
  logic [N_CH-1:0]   step_v;
  logic [PH_W-1:0]   phase_v [N_CH];

  assign wr_hit = cs & wr;
  assign rd_hit = cs & rd;

  always_ff @(posedge clk) begin
    if (rst)                           mode_q <= '0;
    else if (wr_hit && addr == A_MODE) mode_q <= wdata[MODE_W-1:0];
  end

  assign bank_sel = {mode_q[MB_BANK1], mode_q[MB_BANK0]};

  // channel 0 = paper feed, channel 1 = carriage
  assign step_v = {cr_step, pf_step};

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    localparam int               MAN_BIT = 1 + 2 * g;
    localparam int               REV_BIT = 2 + 2 * g;
    localparam logic [AW-1:0]    CH_ADDR = A_PH0 + AW'(g);
    step_phase_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .step     (step_v[g]),
      .auto_en  (~mode_q[MAN_BIT]),
      .reverse  (mode_q[REV_BIT]),
      .wr_en    (wr_hit && addr == CH_ADDR),
      .wr_phase (wdata[PH_W-1:0]),
      .phase    (phase_v[g])
    );
  end

  assign pf_phase = phase_v[0];
  assign cr_phase = phase_v[1];

  head_dot_buf u_head (
    .clk        (clk),
    .rst        (rst),
    .ld_lo      (wr_hit && addr == A_HD_LO),
    .ld_hi      (wr_hit && addr == A_HD_HI),
    .wdata      (wdata),
    .clr_first  (rd_hit && addr == A_HD_HI),
    .clr_second (rd_hit && addr == A_HD_LO),
    .pulse      (drive_pulse),
    .prot_en    (mode_q[MB_PROT]),
    .head_out   (head_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_hit) begin
      unique case (addr)
        A_MODE:            rdata <= DW'(mode_q);
        A_PH0:             rdata <= DW'(phase_v[0]);
        A_PH0 + AW'(1):    rdata <= DW'(phase_v[1]);
        default:           rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/prnmech_ctrl_chk.sv
module prnmech_ctrl_chk
  import prnmech_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     rdata,
  input logic              pf_step,
  input logic              drive_pulse,
  input logic [PH_W-1:0]   pf_phase,
  input logic [PH_W-1:0]   cr_phase,
  input logic [HEAD_W-1:0] head_out,
  input logic [MODE_W-1:0] mode_q
);
  logic rst_d = 1'b0;
  logic pf_wr;

  always_ff @(posedge clk) rst_d <= rst;
  assign pf_wr = cs && wr && addr == A_PH0;

  // R1
  always_ff @(posedge clk) begin
    if (rst_d) begin
      reset_clear_chk: assert (pf_phase == '0 && cr_phase == '0 && head_out == '0 && rdata == '0);
    end
  end

  // R10
  pulse_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_pulse |=> head_out == '0);

  // R6
  manual_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && !pf_wr) |=> $stable(pf_phase));

  // R4
  step_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[1] && $rose(pf_step) && !pf_wr) |=>
      (pf_phase != $past(pf_phase) && $countones(pf_phase) == 2));

  // R3
  phase_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == A_PH0) |=> rdata == DW'($past(pf_phase)));

  // R13
  unused_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr > A_PH0 + AW'(1)) |=> rdata == '0);
endmodule

bind prnmech_ctrl prnmech_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs          (cs),
  .rd          (rd),
  .wr          (wr),
  .addr        (addr),
  .rdata       (rdata),
  .pf_step     (pf_step),
  .drive_pulse (drive_pulse),
  .pf_phase    (pf_phase),
  .cr_phase    (cr_phase),
  .head_out    (head_out),
  .mode_q      (mode_q)
);

// File: tb/sim_prnmech_ctrl.sv
module sim_prnmech_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pf_step = 0, cr_step = 0, drive_pulse = 0;
  logic [3:0] pf_phase, cr_phase;
  logic [8:0] head_out;
  logic [1:0] bank_sel;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  prnmech_ctrl u0 (.*);

  // entry: req[4], op[2] (1 write, 2 read+check), addr[3], data[8], expected[8]
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2,  2'd1, 3'd0, 8'h7F, 8'h00},
    {4'd2,  2'd2, 3'd0, 8'h00, 8'h7F},
    {4'd3,  2'd1, 3'd3, 8'hF5, 8'h00},
    {4'd3,  2'd2, 3'd3, 8'h00, 8'h05},
    {4'd3,  2'd1, 3'd4, 8'h3C, 8'h00},
    {4'd3,  2'd2, 3'd4, 8'h00, 8'h0C},
    {4'd13, 2'd1, 3'd5, 8'hFF, 8'h00},
    {4'd13, 2'd1, 3'd6, 8'hFF, 8'h00},
    {4'd13, 2'd1, 3'd7, 8'hFF, 8'h00},
    {4'd13, 2'd2, 3'd5, 8'h00, 8'h00},
    {4'd13, 2'd2, 3'd7, 8'h00, 8'h00},
    {4'd13, 2'd2, 3'd0, 8'h00, 8'h7F},
    {4'd13, 2'd2, 3'd3, 8'h00, 8'h05},
    {4'd2,  2'd1, 3'd0, 8'h80, 8'h00},
    {4'd2,  2'd2, 3'd0, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); d = rdata; cs = 0; rd = 0;
  endtask

  task automatic step_ch(input bit carriage);
    @(negedge clk); if (carriage) cr_step = 1; else pf_step = 1;
    @(negedge clk); cr_step = 0; pf_step = 0;
  endtask

  task automatic pulse_on;
    @(negedge clk); drive_pulse = 1;
    @(negedge clk);
  endtask

  task automatic pulse_off;
    @(negedge clk); drive_pulse = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pf_phase", 16'(pf_phase), 0);
    chk("R1 cr_phase", 16'(cr_phase), 0);
    chk("R1 head_out", 16'(head_out), 0);
    chk("R1 bank_sel", 16'(bank_sel), 0);
    chk("R1 rdata", 16'(rdata), 0);
    bus_rd(3'd0, rv); chk("R1 mode", 16'(rv), 0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] e;
      e = VEC[i];
      if (e[20:19] == 2'd1) bus_wr(e[18:16], e[15:8]);
      else begin
        bus_rd(e[18:16], rv);
        chk($sformatf("R%0d table entry %0d", e[24:21], i), 16'(rv), 16'(e[7:0]));
      end
    end
    chk("R3 pf_phase port", 16'(pf_phase), 16'h5);
    chk("R3 cr_phase port", 16'(cr_phase), 16'hC);

    // R2 bank selects
    bus_wr(3'd0, 8'h20); chk("R2 bank0", 16'(bank_sel), 16'h1);
    bus_wr(3'd0, 8'h40); chk("R2 bank1", 16'(bank_sel), 16'h2);
    bus_wr(3'd0, 8'h00);

    // R4 forward stepping, paper feed
    bus_wr(3'd3, 8'h0A);
    step_ch(0); chk("R4 pf fwd 1", 16'(pf_phase), 16'h6);
    step_ch(0); chk("R4 pf fwd 2", 16'(pf_phase), 16'h5);
    step_ch(0); chk("R4 pf fwd 3", 16'(pf_phase), 16'h9);
    step_ch(0); chk("R4 pf fwd wrap", 16'(pf_phase), 16'hA);
    // R7 carriage holds 0xC (out of sequence)
    step_ch(1); chk("R7 cr reseed", 16'(cr_phase), 16'hA);
    step_ch(1); chk("R4 cr fwd", 16'(cr_phase), 16'h6);

    // R5 reverse
    bus_wr(3'd0, 8'h04);
    step_ch(0); chk("R5 pf rev 1", 16'(pf_phase), 16'h9);
    step_ch(0); chk("R5 pf rev 2", 16'(pf_phase), 16'h5);
    bus_wr(3'd0, 8'h10);
    step_ch(1); chk("R5 cr rev", 16'(cr_phase), 16'hA);

    // R6 software mode ignores steps
    bus_wr(3'd0, 8'h0A);
    step_ch(0); chk("R6 pf manual", 16'(pf_phase), 16'h5);
    step_ch(1); chk("R6 cr manual", 16'(cr_phase), 16'hA);

    // R6 held step advances once
    bus_wr(3'd0, 8'h00);
    @(negedge clk); pf_step = 1;
    repeat (4) @(negedge clk);
    chk("R6 held step", 16'(pf_phase), 16'h9);
    pf_step = 0;
    @(negedge clk);

    // R8 write and step together
    @(negedge clk); cs = 1; wr = 1; addr = 3'd3; wdata = 8'h06; pf_step = 1;
    @(negedge clk); cs = 0; wr = 0; pf_step = 0;
    chk("R8 write wins", 16'(pf_phase), 16'h6);

    // R9/R10 head path
    bus_wr(3'd2, 8'h81);
    bus_wr(3'd1, 8'h80);
    chk("R10 pulse low", 16'(head_out), 0);
    pulse_on;  chk("R9 transfer", 16'(head_out), 16'h181);
    @(negedge clk); chk("R10 pulse held", 16'(head_out), 16'h181);
    pulse_off; chk("R10 pulse dropped", 16'(head_out), 0);

    // R11 protection
    bus_wr(3'd0, 8'h01);
    bus_wr(3'd2, 8'hFF);
    pulse_on;  chk("R11 suppressed", 16'(head_out), 16'h07E);
    pulse_off;

    // R12 clear second buffer
    bus_rd(3'd2, rv); chk("R12 clear read data", 16'(rv), 0);
    pulse_on;  chk("R12 second cleared", 16'(head_out), 16'h1FF);
    pulse_off;

    // R12 clear first buffer
    bus_wr(3'd0, 8'h00);
    bus_rd(3'd1, rv); chk("R12 clear1 read data", 16'(rv), 0);
    pulse_on;  chk("R12 first cleared", 16'(head_out), 0);
    pulse_off;

    // R11 protection off, R9 first buffer kept
    bus_wr(3'd2, 8'h0F);
    pulse_on;  chk("R9 col a", 16'(head_out), 16'h00F);
    pulse_off;
    pulse_on;  chk("R11 no suppression", 16'(head_out), 16'h00F);
    pulse_off;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule